// File: doc/BRIEF.md
# Debug Access State Controller

This block decides, cycle by cycle, whether the serial debug port of the chip may be used. Two stored values drive that decision. The first is a debug state with four values: Default, Close, Open and Locked. The second is a device lifecycle stage that only moves forward. Both are held in registers that stand in for non-volatile storage. A separate `nv_init` strobe loads the factory contents into that storage. The ordinary system reset `rst` acts as a warm restart: it keeps the stored values, except that a temporary Open falls back to Close.

Firmware or a debug mailbox drives one-cycle command strobes: advance the lifecycle stage, close debug, lock debug permanently, and submit a password word. The password is compared against a reference word supplied on a port. A match while closed reopens debug temporarily. A run of consecutive mismatches disables further attempts until the next reset. Lifecycle requests that do not move strictly forward are refused and raise a sticky error flag.

Top module: `dbg_access_ctrl`

## Requirements
- R1: After `nv_init` the debug state is Default (code 0), the stage is Vendor (code 0), `stage_err`, `pw_lockout` and `pw_fail_cnt` are 0, and `dbg_en` is 1.
- R2: `dbg_en` is 1 in Open and 0 in Close and Locked. In Default it is 1 in the Vendor and OEM stages and 0 in the Deployed and RMA stages. This is combinational from the registered state and stage.
- R3: State codes are Default=0, Close=1, Open=2, Locked=3. `cmd_close` moves Default or Open to Close. `cmd_lock` moves any state to Locked. When strobes coincide, lock beats close, and close beats a password. The new state is visible after the clock edge that samples the strobe.
- R4: Once the state is Locked, no command, password or `rst` changes it; only `nv_init` does.
- R5: A password submitted in Close that equals `ref_pw` moves the state to Open and clears `pw_fail_cnt`. A wrong one leaves the state in Close and adds one to `pw_fail_cnt`.
- R6: After MAX_FAILS consecutive wrong passwords `pw_lockout` becomes 1. Later submissions, correct ones included, change neither the state nor the count until `rst` or `nv_init`.
- R7: A password submitted in Default, Open or Locked, or in the same cycle as `cmd_close` or `cmd_lock`, changes neither the state nor `pw_fail_cnt`.
- R8: `rst` turns Open into Close and keeps Default, Close, Locked and the stage. It clears `pw_fail_cnt`, `pw_lockout` and `stage_err`, and any command in the same cycle is ignored. `nv_init` takes priority over `rst`.
- R9: Stage codes are Vendor=0, OEM=1, Deployed=2, RMA=3. `cmd_advance` with `adv_target` above the current stage loads that target, and skipping stages is allowed.
- R10: `cmd_advance` with `adv_target` equal to or below the current stage leaves the stage unchanged and sets `stage_err`, which stays set until `rst` or `nv_init`.
- R11: A stage advance and a debug-state command in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| nv_init | input | 1 | Synchronous load of factory storage contents |
| rst | input | 1 | Synchronous active-high warm reset |
| cmd_advance | input | 1 | Strobe: request lifecycle stage change |
| adv_target | input | 2 | Requested lifecycle stage |
| cmd_close | input | 1 | Strobe: close debug temporarily |
| cmd_lock | input | 1 | Strobe: lock debug permanently |
| cmd_pw_submit | input | 1 | Strobe: password attempt |
| pw_word | input | PW_W | Submitted password |
| ref_pw | input | PW_W | Stored reference password |
| dbg_en | output | 1 | Debug port allowed |
| dbg_state | output | 2 | Current debug state code |
| lc_stage | output | 2 | Current lifecycle stage code |
| stage_err | output | 1 | Sticky refused-advance flag |
| pw_lockout | output | 1 | Password attempts disabled |
| pw_fail_cnt | output | CNT_W | Consecutive wrong-password count |

## Verification
Two functions can land in the same cycle. A lock can collide with a password attempt, and a lifecycle advance can collide with a close. In the lock case, the lock must win and the attempt must leave no mark on the failure count. In the advance case, both the stage change and the state change must appear after that single edge. Directed steps raise both strobes together on purpose, and the random phase fires every strobe independently so that overlaps recur. A bench model applies the stated priorities and compares every output after each edge.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [1:0] {
        DS_DEFAULT = 2'd0,
        DS_CLOSE   = 2'd1,
        DS_OPEN    = 2'd2,
        DS_LOCKED  = 2'd3
    } dbg_state_e;

    typedef enum logic [1:0] {
        LC_VENDOR   = 2'd0,
        LC_OEM      = 2'd1,
        LC_DEPLOYED = 2'd2,
        LC_RMA      = 2'd3
    } lc_stage_e;

    typedef struct packed {
        logic close;
        logic lock;
        logic pw_try;
    } dbg_cmd_t;

    // A stage request is legal only when it moves strictly forward.
    function automatic logic stage_forward(lc_stage_e cur, lc_stage_e tgt);
        return tgt > cur;
    endfunction

    function automatic logic debug_allowed(dbg_state_e st, lc_stage_e sg);
        logic ok;
        case (st)
            DS_OPEN:    ok = 1'b1;
            DS_DEFAULT: ok = (sg == LC_VENDOR) || (sg == LC_OEM);
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/dbg_lc_stage.sv
module dbg_lc_stage
    import dbg_pkg::*;
(
    input  logic      clk,
    input  logic      nv_init,
    input  logic      rst,
    input  logic      advance,
    input  lc_stage_e target,
    output lc_stage_e stage,
    output logic      err
);
    always_ff @(posedge clk) begin
        if (nv_init) begin
            stage <= LC_VENDOR;
            err   <= 1'b0;
        end else if (rst) begin
            err   <= 1'b0;
        end else if (advance) begin
            if (stage_forward(stage, target)) begin
                stage <= target;
            end else begin
                err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbg_pw_check.sv
module dbg_pw_check #(
    parameter int PW_W      = 32,
    parameter int MAX_FAILS = 3,
    localparam int CNT_W    = $clog2(MAX_FAILS + 1)
) (
    input  logic             clk,
    input  logic             nv_init,
    input  logic             rst,
    input  logic             attempt,
    input  logic [PW_W-1:0]  pw_word,
    input  logic [PW_W-1:0]  ref_pw,
    output logic             pw_good,
    output logic [CNT_W-1:0] fail_cnt,
    output logic             lockout
);
    logic             accept;
    logic             match;
    logic [CNT_W-1:0] cnt_inc;

    assign match   = (pw_word == ref_pw);
    assign accept  = attempt && !lockout;
    assign pw_good = accept && match;
    assign cnt_inc = fail_cnt + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (nv_init || rst) begin
            fail_cnt <= '0;
            lockout  <= 1'b0;
        end else if (accept) begin
            if (match) begin
                fail_cnt <= '0;
            end else begin
                fail_cnt <= cnt_inc;
                if (cnt_inc == CNT_W'(MAX_FAILS)) begin
                    lockout <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dbg_state_fsm.sv
module dbg_state_fsm
    import dbg_pkg::*;
(
    input  logic       clk,
    input  logic       nv_init,
    input  logic       rst,
    input  dbg_cmd_t   cmd,
    input  logic       pw_good,
    output dbg_state_e state,
    output logic       attempt
);
    dbg_state_e state_nx;

    // A password counts only in Close and only when no stronger command competes.
    assign attempt = cmd.pw_try && (state == DS_CLOSE) && !cmd.lock && !cmd.close && !rst;

    always_comb begin
        state_nx = state;
        case (state)
            DS_DEFAULT: begin
                if (cmd.lock)       state_nx = DS_LOCKED;
                else if (cmd.close) state_nx = DS_CLOSE;
            end
            DS_CLOSE: begin
                if (cmd.lock)       state_nx = DS_LOCKED;
                else if (pw_good)   state_nx = DS_OPEN;
            end
            DS_OPEN: begin
                if (cmd.lock)       state_nx = DS_LOCKED;
                else if (cmd.close) state_nx = DS_CLOSE;
            end
            default:                state_nx = DS_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (nv_init) begin
            state <= DS_DEFAULT;
        end else if (rst) begin
            if (state == DS_OPEN) state <= DS_CLOSE;
        end else begin
            state <= state_nx;
        end
    end
endmodule

// File: rtl/dbg_access_ctrl.sv
module dbg_access_ctrl
    import dbg_pkg::*;
#(
    parameter int PW_W      = 32,
    parameter int MAX_FAILS = 3,
    localparam int CNT_W    = $clog2(MAX_FAILS + 1)
) (
    input  logic             clk,
    input  logic             nv_init,
    input  logic             rst,
    input  logic             cmd_advance,
    input  logic [1:0]       adv_target,
    input  logic             cmd_close,
    input  logic             cmd_lock,
    input  logic             cmd_pw_submit,
    input  logic [PW_W-1:0]  pw_word,
    input  logic [PW_W-1:0]  ref_pw,
    output logic             dbg_en,
    output logic [1:0]       dbg_state,
    output logic [1:0]       lc_stage,
    output logic             stage_err,
    output logic             pw_lockout,
    output logic [CNT_W-1:0] pw_fail_cnt
);
    dbg_cmd_t   cmd;
    dbg_state_e st;
    lc_stage_e  sg;
    logic       attempt;
    logic       pw_good;

    assign cmd.close  = cmd_close;
    assign cmd.lock   = cmd_lock;
    assign cmd.pw_try = cmd_pw_submit;

    dbg_lc_stage u_stage (
        .clk     (clk),
        .nv_init (nv_init),
        .rst     (rst),
        .advance (cmd_advance && !rst),
        .target  (lc_stage_e'(adv_target)),
        .stage   (sg),
        .err     (stage_err)
    );

    dbg_pw_check #(
        .PW_W      (PW_W),
        .MAX_FAILS (MAX_FAILS)
    ) u_pw (
        .clk      (clk),
        .nv_init  (nv_init),
        .rst      (rst),
        .attempt  (attempt),
        .pw_word  (pw_word),
        .ref_pw   (ref_pw),
        .pw_good  (pw_good),
        .fail_cnt (pw_fail_cnt),
        .lockout  (pw_lockout)
    );

    dbg_state_fsm u_fsm (
        .clk     (clk),
        .nv_init (nv_init),
        .rst     (rst),
        .cmd     (cmd),
        .pw_good (pw_good),
        .state   (st),
        .attempt (attempt)
    );

    assign dbg_en    = debug_allowed(st, sg);
    assign dbg_state = st;
    assign lc_stage  = sg;
endmodule

// File: rtl/dbg_access_sva.sv
module dbg_access_sva (
    input logic       clk,
    input logic       nv_init,
    input logic       rst,
    input logic       cmd_pw_submit,
    input logic       dbg_en,
    input logic [1:0] dbg_state,
    input logic [1:0] lc_stage,
    input logic       pw_lockout
);
    logic started = 1'b0;
    always_ff @(posedge clk) if (nv_init) started <= 1'b1;

    // R4: Locked survives everything but storage initialisation
    p_locked_sticky_r4: assert property (@(posedge clk) disable iff (nv_init || !started)
        (dbg_state == 2'd3) |=> (dbg_state == 2'd3));

    // R2: Locked or Close never allows debug
    p_closed_no_debug_r2: assert property (@(posedge clk) disable iff (nv_init || !started)
        (dbg_state == 2'd3 || dbg_state == 2'd1) |-> !dbg_en);

    // R2: Deployed/RMA with a state other than Open keeps debug off
    p_late_stage_gate_r2: assert property (@(posedge clk) disable iff (nv_init || !started)
        (lc_stage >= 2'd2 && dbg_state != 2'd2) |-> !dbg_en);

    // R9: the stage never moves backward
    p_stage_forward_r9: assert property (@(posedge clk) disable iff (nv_init || !started)
        1'b1 |=> (lc_stage >= $past(lc_stage)));

    // R8: warm reset turns Open into Close
    p_rst_open_close_r8: assert property (@(posedge clk) disable iff (nv_init || !started)
        (rst && dbg_state == 2'd2) |=> (dbg_state == 2'd1));

    // R6: with attempts disabled, Close cannot become Open
    p_lockout_holds_r6: assert property (@(posedge clk) disable iff (nv_init || !started)
        (pw_lockout && dbg_state == 2'd1) |=> (dbg_state != 2'd2));

    // R5: Open is reached from Close only through a password attempt
    p_open_needs_pw_r5: assert property (@(posedge clk) disable iff (nv_init || !started)
        (dbg_state == 2'd1 && !cmd_pw_submit) |=> (dbg_state != 2'd2));
endmodule

bind dbg_access_ctrl dbg_access_sva u_sva (
    .clk           (clk),
    .nv_init       (nv_init),
    .rst           (rst),
    .cmd_pw_submit (cmd_pw_submit),
    .dbg_en        (dbg_en),
    .dbg_state     (dbg_state),
    .lc_stage      (lc_stage),
    .pw_lockout    (pw_lockout)
);

// File: tb/dbg_access_ctrl_bench.sv
`timescale 1ns/1ps
module dbg_access_ctrl_bench;
    localparam int PW_W      = 32;
    localparam int MAX_FAILS = 3;
    localparam int CNT_W     = $clog2(MAX_FAILS + 1);
    localparam logic [PW_W-1:0] REF = 32'hC0DE_1234;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             nv_init = 1'b1, rst = 1'b0;
    logic             cmd_advance = 1'b0, cmd_close = 1'b0, cmd_lock = 1'b0, cmd_pw_submit = 1'b0;
    logic [1:0]       adv_target = 2'd0;
    logic [PW_W-1:0]  pw_word = '0;
    logic [PW_W-1:0]  ref_pw = REF;
    logic             dbg_en, stage_err, pw_lockout;
    logic [1:0]       dbg_state, lc_stage;
    logic [CNT_W-1:0] pw_fail_cnt;

    dbg_access_ctrl #(.PW_W(PW_W), .MAX_FAILS(MAX_FAILS)) u_dbg_access_ctrl (
        .clk(clk), .nv_init(nv_init), .rst(rst), .cmd_advance(cmd_advance),
        .adv_target(adv_target), .cmd_close(cmd_close), .cmd_lock(cmd_lock),
        .cmd_pw_submit(cmd_pw_submit), .pw_word(pw_word), .ref_pw(ref_pw),
        .dbg_en(dbg_en), .dbg_state(dbg_state), .lc_stage(lc_stage),
        .stage_err(stage_err), .pw_lockout(pw_lockout), .pw_fail_cnt(pw_fail_cnt));

    int total = 0, bad = 0;
    logic [1:0] m_st, m_sg;
    int         m_cnt;
    logic       m_lo, m_err;

    function automatic logic exp_en(logic [1:0] st, logic [1:0] sg);
        if (st == 2'd2) return 1'b1;
        if (st == 2'd0) return sg < 2'd2;
        return 1'b0;
    endfunction

    // Expected next-state model, from the requirement text.
    task automatic model_step();
        logic try_ok;
        if (nv_init) begin
            m_st = 2'd0; m_sg = 2'd0; m_cnt = 0; m_lo = 1'b0; m_err = 1'b0;
        end else if (rst) begin
            if (m_st == 2'd2) m_st = 2'd1;
            m_cnt = 0; m_lo = 1'b0; m_err = 1'b0;
        end else begin
            if (cmd_advance) begin
                if (adv_target > m_sg) m_sg = adv_target; else m_err = 1'b1;
            end
            try_ok = cmd_pw_submit && m_st == 2'd1 && !cmd_lock && !cmd_close && !m_lo;
            if (m_st != 2'd3 && cmd_lock) m_st = 2'd3;
            else if ((m_st == 2'd0 || m_st == 2'd2) && cmd_close) m_st = 2'd1;
            else if (try_ok) begin
                if (pw_word == REF) begin m_st = 2'd2; m_cnt = 0; end
                else begin
                    m_cnt = m_cnt + 1;
                    if (m_cnt == MAX_FAILS) m_lo = 1'b1;
                end
            end
        end
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cycle(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(tag, "dbg_state", dbg_state, m_st);
        chk(tag, "lc_stage", lc_stage, m_sg);
        chk(tag, "dbg_en", dbg_en, exp_en(m_st, m_sg));
        chk(tag, "stage_err", stage_err, m_err);
        chk(tag, "pw_lockout", pw_lockout, m_lo);
        chk(tag, "pw_fail_cnt", pw_fail_cnt, m_cnt);
        nv_init = 0; rst = 0; cmd_advance = 0; cmd_close = 0; cmd_lock = 0; cmd_pw_submit = 0;
    endtask

    task automatic pw(logic ok, string tag);
        cmd_pw_submit = 1; pw_word = ok ? REF : REF ^ 32'h10;
        cycle(tag);
    endtask

    task automatic adv(logic [1:0] t, string tag);
        cmd_advance = 1; adv_target = t;
        cycle(tag);
    endtask

    initial begin
        #(200000 * 4);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        logic [31:0] r;
        seed = 20240611;
        r = $urandom(seed);
        @(negedge clk);
        nv_init = 1; cycle("R1 factory init");
        adv(2'd1, "R9 advance to OEM, R2 default debug on");
        adv(2'd1, "R10 repeat stage refused");
        adv(2'd0, "R10 backward refused");
        rst = 1; cycle("R8 rst clears stage_err");
        pw(1, "R7 password ignored in Default");
        cmd_close = 1; cycle("R3 close from Default");
        pw(0, "R5 wrong password counts");
        pw(0, "R5 second wrong password");
        pw(1, "R5 correct password opens");
        cmd_close = 1; cmd_pw_submit = 1; pw_word = REF; cycle("R3 close beats password");
        pw(1, "R5 reopen");
        pw(0, "R7 password ignored in Open");
        rst = 1; cycle("R8 rst Open to Close");
        pw(0, "R6 fail 1"); pw(0, "R6 fail 2"); pw(0, "R6 fail 3 locks out");
        pw(1, "R6 correct ignored in lockout");
        rst = 1; cycle("R8 rst clears lockout");
        pw(1, "R6 accepted after rst");
        cmd_close = 1; cmd_advance = 1; adv_target = 2'd2; cycle("R11 advance and close together");
        pw(1, "R2 Deployed Open enables");
        adv(2'd3, "R9 advance to RMA");
        cmd_close = 1; cycle("R2 RMA closed off");
        pw(1, "R2 RMA open after auth");
        cmd_lock = 1; cmd_pw_submit = 1; pw_word = REF ^ 1; cycle("R3 lock beats password");
        pw(1, "R4 password cannot unlock");
        cmd_close = 1; cycle("R4 close has no effect on Locked");
        rst = 1; cycle("R4 Locked survives rst");
        nv_init = 1; rst = 1; cycle("R8 nv_init beats rst");
        adv(2'd2, "R9 skip to Deployed, R2 Default off");
        nv_init = 1; cycle("R1 reinit");
        for (int i = 0; i < 3000; i++) begin
            r = $urandom;
            nv_init       = (r[5:0] == 6'd0);
            rst           = (r[10:6] == 5'd1);
            cmd_advance   = (r[14:11] == 4'd2);
            adv_target    = r[16:15];
            cmd_close     = (r[20:17] == 4'd3);
            cmd_lock      = (r[27:21] == 7'd5);
            cmd_pw_submit = r[28];
            pw_word       = r[30:29] == 2'd0 ? REF ^ 32'h4 : REF;
            cycle("R11 random mix");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule